// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block is a synchronous master for a 32K x 8 asynchronous static memory. It takes one-word read or write requests over a valid/ready handshake. It turns each request into a sequence of active-low chip-select, output-enable and write-enable strobes, with a registered address and a shared bidirectional byte bus. Read data comes back on a single-cycle response strobe.

Every timing minimum of the memory is given in nanoseconds as a parameter, next to the clock period. The controller rounds each one up to a whole number of clock cycles and holds each phase of a cycle for that many clocks. A write-protect input from the power supervisor stops new cycles from starting. A cycle that has already begun always runs to its end.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, all three strobes are high, the response strobe is low, the data bus is not driven by the controller and ready is high while write-protect is low.
- R2: A read accepted at a clock edge drives chip-select and output-enable low with write-enable high, starting at that edge, for RD = max(ceil(tRC/P), ceil(tACC/P), ceil(tOE/P)) cycles (10 with P=10 ns). At the end of those cycles the strobes return high and the response strobe is high for exactly one cycle, carrying the byte on the bus during the last low cycle.
- R3: A write accepted at a clock edge first spends one setup cycle with the strobes high. Chip-select and write-enable then fall together and stay low for WP = max(ceil(tWP/P), ceil(tDS/P)) cycles (8 with P=10 ns), and then rise together.
- R4: Output-enable stays high during every cycle of a write.
- R5: The memory address equals the requested address from the first strobe cycle to the end of the cycle and never changes while chip-select is low. During a write the bus carries the requested byte from the setup cycle to the end of the pulse.
- R6: After a write pulse the strobes stay high for REC = max(ceil(tWR/P), ceil(tWC/P) - 1 - WP, 1) cycles (1 with P=10 ns) while the bus is still driven. The controller is then idle.
- R7: The controller drives the bus only in the setup, pulse and recovery cycles of a write. Output-enable falls only when the bus was already released in the cycle before.
- R8: While write-protect is high, ready is low and no new cycle starts, however long a request is held. A cycle already running when protect rises completes unchanged.
- R9: Ready is high only while the controller is idle and unprotected. It is low from the cycle after acceptance until the cycle after the last strobe cycle (reads) or the last recovery cycle (writes).
- R10: A byte written to an address is returned by a later read of that address, including the all-zero and all-one patterns and the highest address 0x7FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 8 | Write byte |
| wprot_i | input | 1 | Write-protect from the power supervisor, blocks new cycles |
| rsp_valid_o | output | 1 | One-cycle strobe marking read data |
| rsp_rdata_o | output | 8 | Read byte |
| mem_addr_o | output | 15 | Memory address |
| mem_cs_no | output | 1 | Memory chip-select, active low |
| mem_oe_no | output | 1 | Memory output-enable, active low |
| mem_we_no | output | 1 | Memory write-enable, active low |
| mem_dq_io | inout | 8 | Shared memory data bus |

## Verification
All strobes are registers. Each one changes at the same edge that accepts a request, so the first strobe cycle is the first cycle after acceptance. For a read, the response strobe is due exactly RD cycles after the accepting edge. For a write, the pulse covers cycles 2 to 1+WP after acceptance, recovery follows, and ready returns at cycle 2+WP+REC. Each task waits for the accepting edge, then samples the ports at every following falling clock edge and compares them against that cycle index. The index is worked out from the bench's own copy of the rounding rules.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSET,
        ST_WPULSE,
        ST_WREC
    } seq_state_e;

    // nanoseconds to whole clock cycles, rounding up
    function automatic int ceil_cycles(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_dq.sv
module sram_seq_dq #(
    parameter int DATA_W = 8
) (
    input  logic              drive_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    inout  wire  [DATA_W-1:0] pad_io
);
    assign pad_io  = drive_i ? wdata_i : {DATA_W{1'bz}};
    assign rdata_o = pad_io;
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 100,
    parameter int T_ACC_NS      = 100,
    parameter int T_OE_NS       = 50,
    parameter int T_WP_NS       = 75,
    parameter int T_WC_NS       = 100,
    parameter int T_DS_NS       = 40,
    parameter int T_WR_NS       = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              wprot_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs_no,
    output logic              mem_oe_no,
    output logic              mem_we_no,
    inout  wire  [DATA_W-1:0] mem_dq_io
);
    // phase lengths in clock cycles
    localparam int RD_CYC  = max2(max2(ceil_cycles(T_RC_NS, CLK_PERIOD_NS),
                                       ceil_cycles(T_ACC_NS, CLK_PERIOD_NS)),
                                  max2(ceil_cycles(T_OE_NS, CLK_PERIOD_NS), 1));
    localparam int SU_CYC  = 1;
    localparam int WP_CYC  = max2(max2(ceil_cycles(T_WP_NS, CLK_PERIOD_NS),
                                       ceil_cycles(T_DS_NS, CLK_PERIOD_NS)), 1);
    localparam int WC_CYC  = ceil_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int REC_CYC = max2(max2(ceil_cycles(T_WR_NS, CLK_PERIOD_NS), 1),
                                  WC_CYC - SU_CYC - WP_CYC);
    localparam int MAX_CYC = max2(max2(RD_CYC, WP_CYC), max2(REC_CYC, SU_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              cs_n;
        logic              oe_n;
        logic              we_n;
        logic              drive;
        logic              rsp;
    } seq_regs_t;

    localparam seq_regs_t REGS_RESET = '{
        state: ST_IDLE,
        addr:  '0,
        wdata: '0,
        rdata: '0,
        cs_n:  1'b1,
        oe_n:  1'b1,
        we_n:  1'b1,
        drive: 1'b0,
        rsp:   1'b0
    };

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic [DATA_W-1:0] bus_in;
    logic             dq_drive;

    sram_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    assign dq_drive = r_q.drive;

    sram_seq_dq #(.DATA_W(DATA_W)) dq_i (
        .drive_i (dq_drive),
        .wdata_i (r_q.wdata),
        .rdata_o (bus_in),
        .pad_io  (mem_dq_io)
    );

    always_comb begin
        r_d      = r_q;
        r_d.rsp  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid_i && !wprot_i) begin
                    r_d.addr  = req_addr_i;
                    r_d.wdata = req_wdata_i;
                    tmr_load  = 1'b1;
                    if (req_write_i) begin
                        r_d.state = ST_WSET;
                        r_d.drive = 1'b1;
                        tmr_val   = CNT_W'(SU_CYC - 1);
                    end else begin
                        r_d.state = ST_READ;
                        r_d.cs_n  = 1'b0;
                        r_d.oe_n  = 1'b0;
                        tmr_val   = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                    r_d.cs_n  = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.rdata = bus_in;
                    r_d.rsp   = 1'b1;
                end
            end
            ST_WSET: begin
                if (tmr_done) begin
                    r_d.state = ST_WPULSE;
                    r_d.cs_n  = 1'b0;
                    r_d.we_n  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(WP_CYC - 1);
                end
            end
            ST_WPULSE: begin
                if (tmr_done) begin
                    r_d.state = ST_WREC;
                    r_d.cs_n  = 1'b1;
                    r_d.we_n  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WREC: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                    r_d.drive = 1'b0;
                end
            end
            default: begin
                r_d = REGS_RESET;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= REGS_RESET;
        else         r_q <= r_d;
    end

    assign req_ready_o = (r_q.state == ST_IDLE) && !wprot_i;
    assign rsp_valid_o = r_q.rsp;
    assign rsp_rdata_o = r_q.rdata;
    assign mem_addr_o  = r_q.addr;
    assign mem_cs_no   = r_q.cs_n;
    assign mem_oe_no   = r_q.oe_n;
    assign mem_we_no   = r_q.we_n;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_WP_NS       = 75,
    parameter int T_DS_NS       = 40
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_ready_o,
    input logic              wprot_i,
    input logic              rsp_valid_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_cs_no,
    input logic              mem_oe_no,
    input logic              mem_we_no,
    input logic              drive_i
);
    localparam int WP_MIN = max2(ceil_cycles(T_WP_NS, CLK_PERIOD_NS),
                                 ceil_cycles(T_DS_NS, CLK_PERIOD_NS));

    logic [15:0] we_run;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         we_run <= '0;
        else if (!mem_we_no) we_run <= we_run + 16'd1;
        else                 we_run <= '0;
    end

    assert_read_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_oe_no |-> (mem_we_no && !mem_cs_no));

    assert_rsp_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |=> !rsp_valid_o);

    assert_we_with_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_we_no |-> !mem_cs_no);

    assert_pulse_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_no) |-> (we_run >= 16'(WP_MIN)));

    assert_oe_off_in_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mem_we_no || drive_i) |-> mem_oe_no);

    assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o));

    assert_recovery_driven_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mem_we_no) |-> drive_i);

    assert_bus_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(mem_oe_no) |-> (!drive_i && !$past(drive_i)));

    assert_protect_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wprot_i |-> !req_ready_o);

    assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> (mem_cs_no && !drive_i));
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_WP_NS       (T_WP_NS),
    .T_DS_NS       (T_DS_NS)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_ready_o (req_ready_o),
    .wprot_i     (wprot_i),
    .rsp_valid_o (rsp_valid_o),
    .mem_addr_o  (mem_addr_o),
    .mem_cs_no   (mem_cs_no),
    .mem_oe_no   (mem_oe_no),
    .mem_we_no   (mem_we_no),
    .drive_i     (dq_drive)
);

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;
    localparam int CLK_NS = 10;

    function automatic int up_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // expected phase lengths from the requirements, default timings
    localparam int E_RD  = imax(imax(up_div(100, CLK_NS), up_div(100, CLK_NS)), up_div(50, CLK_NS));
    localparam int E_WP  = imax(up_div(75, CLK_NS), up_div(40, CLK_NS));
    localparam int E_REC = imax(imax(up_div(5, CLK_NS), 1), up_div(100, CLK_NS) - 1 - E_WP);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        wprot = 1'b0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic        cs_n, oe_n, we_n;
    wire  [7:0]  mem_dq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    sram_seq_ctrl dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .wprot_i     (wprot),
        .rsp_valid_o (rsp_valid),
        .rsp_rdata_o (rsp_rdata),
        .mem_addr_o  (mem_addr),
        .mem_cs_no   (cs_n),
        .mem_oe_no   (oe_n),
        .mem_we_no   (we_n),
        .mem_dq_io   (mem_dq)
    );

    // small memory model, indexed by the low address byte
    logic [7:0]  mem_arr [256];
    logic        wr_pend = 1'b0;
    logic [14:0] wr_a;
    logic [7:0]  wr_d;

    assign mem_dq = (!cs_n && !oe_n && we_n) ? mem_arr[mem_addr[7:0]] : 8'bz;

    always @(negedge clk) begin
        if (!cs_n && !we_n) begin
            wr_pend = 1'b1;
            wr_a    = mem_addr;
            wr_d    = mem_dq;
        end else if (wr_pend) begin
            mem_arr[wr_a[7:0]] = wr_d;
            wr_pend = 1'b0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    // present a request and return after the accepting edge, at the next falling edge
    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "strobes in reset", {cs_n, oe_n, we_n}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "strobes after reset", {cs_n, oe_n, we_n}, 3'b111);
        chk("R1", "rsp after reset", rsp_valid, 0);
        chk("R1", "ready after reset", req_ready, 1);
    endtask

    task automatic t_read(input logic [14:0] a, input logic [7:0] exp);
        int low = 0;
        issue(1'b0, a, 8'h00);
        for (int k = 1; k <= E_RD; k++) begin
            if (k > 1) @(negedge clk);
            if (!cs_n && !oe_n && we_n && mem_addr == a) low++;
            if (k == 1) begin
                chk("R9", "ready in read", req_ready, 0);
                chk("R7", "bus holds memory byte", mem_dq, exp);
            end
        end
        chk("R2", "read strobe cycles", low, E_RD);
        @(negedge clk);
        chk("R2", "strobes high after read", {cs_n, oe_n, we_n}, 3'b111);
        chk("R2", "rsp due", rsp_valid, 1);
        chk("R10", "read byte", rsp_rdata, exp);
        chk("R9", "ready after read", req_ready, !wprot);
        @(negedge clk);
        chk("R2", "rsp single cycle", rsp_valid, 0);
    endtask

    task automatic t_write(input logic [14:0] a, input logic [7:0] d, input bit raise_prot);
        int low = 0;
        int bad = 0;
        issue(1'b1, a, d);
        chk("R3", "setup strobes", {cs_n, oe_n, we_n}, 3'b111);
        chk("R5", "setup addr", mem_addr, a);
        chk("R5", "setup data", mem_dq, d);
        if (raise_prot) wprot = 1'b1;
        for (int k = 2; k <= 1 + E_WP; k++) begin
            @(negedge clk);
            if (!cs_n && !we_n) low++;
            if (oe_n != 1'b1) bad++;
            if (mem_addr != a || mem_dq != d) bad++;
        end
        chk("R3", "pulse cycles", low, E_WP);
        chk("R4", "oe low in pulse", bad, 0);
        for (int k = 0; k < E_REC; k++) begin
            @(negedge clk);
            chk("R6", "recovery strobes", {cs_n, oe_n, we_n}, 3'b111);
            chk("R9", "ready in recovery", req_ready, 0);
        end
        @(negedge clk);
        chk("R9", "ready after write", req_ready, !wprot);
        chk("R6", "idle strobes", {cs_n, oe_n, we_n}, 3'b111);
    endtask

    task automatic t_protect();
        int starts = 0;
        int rdy = 0;
        wprot = 1'b1;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 15'h0055;
        req_wdata = 8'h99;
        repeat (20) begin
            @(negedge clk);
            if (!cs_n || !we_n || !oe_n) starts++;
            if (req_ready) rdy++;
        end
        chk("R8", "strobes under protect", starts, 0);
        chk("R8", "ready under protect", rdy, 0);
        req_valid = 1'b0;
        wprot = 1'b0;
        @(negedge clk);
        chk("R8", "ready after protect", req_ready, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_arr[i] = 8'(i ^ 8'h5A);
        mem_arr[8'h12] = 8'hA5;
        t_reset();
        t_read(15'h0012, 8'hA5);
        t_write(15'h7F33, 8'h3C, 1'b0);
        t_read(15'h7F33, 8'h3C);
        t_write(15'h0044, 8'h00, 1'b0);
        t_read(15'h0044, 8'h00);
        t_write(15'h7FFF, 8'hFF, 1'b0);
        chk("R10", "highest addr written", mem_arr[8'hFF], 8'hFF);
        t_read(15'h7FFF, 8'hFF);
        t_protect();
        t_read(15'h0055, 8'(8'h55 ^ 8'h5A));
        t_write(15'h0066, 8'hC3, 1'b1);
        wprot = 1'b0;
        t_read(15'h0066, 8'hC3);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            finish_run();
        end
    end
endmodule